// File: doc/BRIEF.md
# Parallel Port FIFO Service Request

A byte FIFO for the buffered modes of a parallel port, together with the logic that decides when the port needs service from DMA or from the CPU. Which side loads the FIFO depends on the transfer direction. In the forward direction (host to peripheral), the host writes bytes and the peripheral engine reads them. In the reverse direction, the peripheral engine writes bytes and the host reads them.

Service is requested through a level. In the reverse direction, the level is raised when enough bytes are waiting. In the forward direction, it is raised when enough slots are free. A select input chooses between two threshold pairs. One is a lopsided pair: one free slot going forward, fifteen held bytes going in reverse. The other is eight in both directions. The request only leaves the block when the FIFO mode is on and the matching path (DMA or interrupt) is enabled.

Turning the port around empties the FIFO. A push into a full FIFO or a pop from an empty one is refused and recorded in a sticky error flag.

Top module: `ppfifo_svc_req`

## Requirements
- R1: While reset is held and right after it, `empty`=1, `full`=0, `level`=0, `err_flag`=0, and both requests are low.
- R2: Bytes leave in the order they entered. `level` counts the held bytes from 0 to 16. `full` is 1 at 16 and `empty` is 1 at 0. Read data is the oldest byte, valid while the FIFO is not empty.
- R3: With `dir_rev`=0, `host_wr` pushes and `per_rd` pops. With `dir_rev`=1, `per_wr` pushes and `host_rd` pops. Strobes of the side that is not active for the direction leave `level` unchanged.
- R4: With `thr_sel`=1, the threshold is 1 in the forward direction and 15 in the reverse direction.
- R5: With `thr_sel`=0, the threshold is 8 in both directions.
- R6: The service condition is met when free slots (16 − level) ≥ threshold going forward, or when level ≥ threshold in reverse. The request appears one clock after `level` first meets the condition and drops one clock after it stops meeting it.
- R7: With `fifo_mode_en`=0, neither request is raised from the next clock on.
- R8: `dma_req` can only be high while `dma_en`=1. `irq_req` can only be high while `irq_en`=1.
- R9: A clock cycle in which `dir_rev` differs from its value at the previous edge is a flush cycle. Both requests are low during that cycle, and `level` is 0 after its closing edge.
- R10: A push while full, or a pop while empty, is ignored (`level` is unchanged) and sets `err_flag`. The flag stays set until `err_clr`=1 is applied for one clock. A new error in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode_en | input | 1 | Port is in a FIFO-based mode |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| thr_sel | input | 1 | Threshold pair select |
| dma_en | input | 1 | DMA request path enable |
| irq_en | input | 1 | Interrupt request path enable |
| host_wr | input | 1 | Host push strobe (forward) |
| host_wdata | input | 8 | Host push byte |
| host_rd | input | 1 | Host pop strobe (reverse) |
| host_rdata | output | 8 | Oldest byte, host view |
| per_wr | input | 1 | Peripheral push strobe (reverse) |
| per_wdata | input | 8 | Peripheral push byte |
| per_rd | input | 1 | Peripheral pop strobe (forward) |
| per_rdata | output | 8 | Oldest byte, peripheral view |
| err_clr | input | 1 | Write-one clear of the error flag |
| dma_req | output | 1 | DMA service request |
| irq_req | output | 1 | Interrupt service request |
| full | output | 1 | FIFO holds 16 bytes |
| empty | output | 1 | FIFO holds no bytes |
| level | output | 5 | Number of held bytes |
| err_flag | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench uses the default parameters: depth 16, threshold pair 1/15 and symmetric value 8. With a depth this small, a few dozen strobes reach every threshold edge: the 8/9 crossing, the completely full FIFO where one free slot decides the forward request, and the 15-byte mark in reverse. The same settings reach both overflow and underflow, and allow a direction flip with a partly filled FIFO, so the flush behaviour is seen with data present.

// File: rtl/ppfifo_svc_req.sv
module ppfifo_svc_req #(
  parameter int DEPTH        = 16,
  parameter int WIDTH        = 8,
  parameter int THR_FWD_ASYM = 1,
  parameter int THR_REV_ASYM = 15,
  parameter int THR_SYM      = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode_en,
  input  logic             dir_rev,
  input  logic             thr_sel,
  input  logic             dma_en,
  input  logic             irq_en,
  input  logic             host_wr,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_rd,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             per_wr,
  input  logic [WIDTH-1:0] per_wdata,
  input  logic             per_rd,
  output logic [WIDTH-1:0] per_rdata,
  input  logic             err_clr,
  output logic             dma_req,
  output logic             irq_req,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    level,
  output logic             err_flag
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             dir_q, req_q, err_q;

  wire             flush     = dir_rev != dir_q;
  wire             push_req  = dir_rev ? per_wr : host_wr;
  wire             pop_req   = dir_rev ? host_rd : per_rd;
  wire [WIDTH-1:0] push_data = dir_rev ? per_wdata : host_wdata;
  wire             is_full   = cnt == CW'(DEPTH);
  wire             is_empty  = cnt == '0;
  wire             do_push   = !flush && push_req && !is_full;
  wire             do_pop    = !flush && pop_req && !is_empty;
  wire             bad       = !flush && ((push_req && is_full) || (pop_req && is_empty));

  logic [CW-1:0] thr;
  always_comb begin
    if (thr_sel) thr = dir_rev ? CW'(THR_REV_ASYM) : CW'(THR_FWD_ASYM);
    else         thr = CW'(THR_SYM);
  end

  wire [CW-1:0] free_slots = CW'(DEPTH) - cnt;
  wire          hit        = dir_rev ? (cnt >= thr) : (free_slots >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      dir_q  <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      dir_q  <= dir_rev;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= fifo_mode_en && !flush && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (bad)     err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  assign host_rdata = mem[rd_ptr];
  assign per_rdata  = mem[rd_ptr];
  assign dma_req    = req_q && dma_en && !flush;
  assign irq_req    = req_q && irq_en && !flush;
  assign full       = is_full;
  assign empty      = is_empty;
  assign level      = cnt;
  assign err_flag   = err_q;

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r2_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r10_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push_req && is_full && !pop_req) |=> full);

  a_r10_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> err_flag);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  a_r7_mode_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode_en |=> !(dma_req || irq_req));

endmodule

// File: tb/ppfifo_svc_req_tb.sv
module ppfifo_svc_req_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic fifo_mode_en = 1, dir_rev = 0, thr_sel = 0, dma_en = 1, irq_en = 1;
  logic host_wr = 0, host_rd = 0, per_wr = 0, per_rd = 0, err_clr = 0;
  logic [7:0] host_wdata = 0, per_wdata = 0;
  logic [7:0] host_rdata, per_rdata;
  logic dma_req, irq_req, full, empty, err_flag;
  logic [4:0] level;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q [$];

  always #2 clk = ~clk;

  ppfifo_svc_req u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode_en(fifo_mode_en), .dir_rev(dir_rev),
    .thr_sel(thr_sel), .dma_en(dma_en), .irq_en(irq_en),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .per_wr(per_wr), .per_wdata(per_wdata), .per_rd(per_rd), .per_rdata(per_rdata),
    .err_clr(err_clr), .dma_req(dma_req), .irq_req(irq_req),
    .full(full), .empty(empty), .level(level), .err_flag(err_flag));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(bit side_per, logic [7:0] d);
    if (side_per) begin per_wr = 1; per_wdata = d; end
    else          begin host_wr = 1; host_wdata = d; end
    if (exp_q.size() < 16) exp_q.push_back(d);
    tick();
    per_wr = 0; host_wr = 0;
  endtask

  task automatic pop(bit side_host);
    if (exp_q.size() > 0) begin
      check("R2 fifo order", side_host ? host_rdata : per_rdata, exp_q[0]);
      void'(exp_q.pop_front());
    end
    if (side_host) host_rd = 1; else per_rd = 1;
    tick();
    host_rd = 0; per_rd = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 empty", empty, 1); check("R1 full", full, 0);
    check("R1 level", level, 0); check("R1 err", err_flag, 0);
    check("R1 dma", dma_req, 0); check("R1 irq", irq_req, 0);
    rst_n = 1;
    tick();
    check("R6 fwd empty request", dma_req, 1);
    for (int i = 0; i < 9; i++) push(0, 8'hA0 + 8'(i));
    check("R2 level 9", level, 9);
    check("R6 request lags one clock", dma_req, 1);
    tick();
    check("R5 fwd free 7 below 8", dma_req, 0);
    dma_en = 0;
    pop(0); pop(0);
    tick();
    check("R8 irq path", irq_req, 1);
    check("R8 dma gated", dma_req, 0);
    dma_en = 1; thr_sel = 1;
    for (int i = 0; i < 9; i++) push(0, 8'hC0 + 8'(i));
    check("R2 full", full, 1);
    tick();
    check("R4 fwd no free slot", irq_req, 0);
    push(0, 8'hEE);
    check("R10 overflow level", level, 16);
    check("R10 overflow flag", err_flag, 1);
    tick();
    check("R10 sticky", err_flag, 1);
    err_clr = 1; tick(); err_clr = 0;
    check("R10 cleared", err_flag, 0);
    pop(0);
    tick();
    check("R4 fwd one free slot", irq_req, 1);
    fifo_mode_en = 0; tick(); tick();
    check("R7 mode off", irq_req, 0);
    check("R7 mode off dma", dma_req, 0);
    fifo_mode_en = 1;
    per_wr = 1; host_rd = 1; tick(); per_wr = 0; host_rd = 0;
    check("R3 inactive strobes ignored", level, 15);
    for (int i = 0; i < 15; i++) pop(0);
    check("R2 empty", empty, 1);
    pop(0);
    check("R10 underflow flag", err_flag, 1);
    check("R10 underflow level", level, 0);
    err_clr = 1; tick(); err_clr = 0;
    tick();
    check("R6 request up before flip", irq_req, 1);
    dir_rev = 1; #1;
    check("R9 request low in flush", irq_req, 0);
    check("R9 dma low in flush", dma_req, 0);
    tick();
    thr_sel = 0;
    for (int i = 0; i < 7; i++) push(1, 8'h30 + 8'(i));
    tick();
    check("R5 rev 7 below 8", irq_req, 0);
    push(1, 8'h37);
    check("R6 rev lag", irq_req, 0);
    tick();
    check("R5 rev 8 reached", irq_req, 1);
    host_wr = 1; tick(); host_wr = 0;
    check("R3 host push ignored in reverse", level, 8);
    thr_sel = 1; tick();
    check("R4 rev 8 below 15", irq_req, 0);
    for (int i = 0; i < 7; i++) push(1, 8'h50 + 8'(i));
    check("R2 level 15", level, 15);
    tick();
    check("R4 rev 15 reached", dma_req, 1);
    pop(1); pop(1); pop(1);
    check("R3 host pops in reverse", level, 12);
    dir_rev = 0; #1;
    check("R9 flush with data", dma_req, 0);
    tick();
    exp_q.delete();
    check("R9 level after flush", level, 0);
    check("R9 empty after flush", empty, 1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule